// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block is the coherence engine of one private cache in a shared-bus multiprocessor. It holds a direct-mapped array of lines. Each line has a tag, one data word and a coherence state: invalid, shared or modified. The block serves load and store requests from its own processor. When a request cannot be served locally, the block raises a bus request and, once granted, drives one bus transaction: a shared read, an exclusive read, an ownership upgrade or a writeback of a dirty victim.

Every cache on the bus sees each granted transaction of the other caches on its snoop port, in the order the arbiter grants them. A store can finish only when its cache holds the line in the modified state. To get there, the cache drives a transaction that makes every other copy invalid. A snooped read that hits a modified line makes the owner drive its word in the same cycle and keep the line as shared. The system bus merges that word into the response data and into memory. Snoops take priority over the processor: a processor access never completes in a cycle in which a snoop is presented.

Top module: `coh_snoop_cache`

## Requirements
- R1: After reset every line is invalid, busReq and flushOut are low, and the first access to any address causes a bus transaction.
- R2: A load that hits a shared or modified line, and a store that hits a modified line, complete with cpuDone and no bus transaction. A load returns the stored word on cpuRdata.
- R3: A load miss issues a shared read (busCmd code 0) and installs the line as shared, with the word from busRespData.
- R4: A store to a line that is not held issues an exclusive read (code 1). A store to a line held as shared issues an upgrade (code 2). In both cases the line ends up modified and the store data is written into it.
- R5: A snooped shared read that hits a modified line asserts flushOut in that cycle with the line's word on flushData, and leaves the line shared.
- R6: A snooped exclusive read or upgrade that hits a valid line leaves it invalid. If the line was modified, flushOut is asserted with its word in that cycle.
- R7: Replacing a modified victim first issues a writeback (code 3) carrying the victim's address and word, and only then the fill transaction. A clean victim is replaced with no writeback.
- R8: cpuDone is never asserted in a cycle in which snpValid is high.
- R9: Every load returns the most recently stored value of its address, system-wide. Competing stores to one address are seen in one order by all caches.
- R10: A fill request, once raised and not granted, stays raised with an unchanged busAddr in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor access request, held until cpuDone |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Word address of the access |
| cpuWdata | input | DATA_W | Store data |
| cpuDone | output | 1 | Access completes at this clock edge |
| cpuRdata | output | DATA_W | Load data, valid with cpuDone |
| busReq | output | 1 | Request for the shared bus |
| busGnt | input | 1 | Grant; the transaction happens in this cycle |
| busCmd | output | 2 | 0 shared read, 1 exclusive read, 2 upgrade, 3 writeback |
| busAddr | output | ADDR_W | Transaction address |
| busData | output | DATA_W | Writeback word |
| busRespData | input | DATA_W | Fill word from memory or a flushing cache |
| snpValid | input | 1 | Another cache's transaction is on the bus |
| snpCmd | input | 2 | Snooped command, same coding as busCmd |
| snpAddr | input | ADDR_W | Snooped address |
| flushOut | output | 1 | This cache supplies the snooped line's word |
| flushData | output | DATA_W | Supplied word |

## Verification
The bench builds two caches with ADDR_W=5, IDX_W=2 and DATA_W=8 on a round-robin bus with a 32-word memory. With only four lines and eight tags per line, a short sweep reaches every address, every state transition, clean and dirty evictions, and snoops that land while a writeback or fill is still waiting for the bus. Stores from both caches race for the same addresses. This shows that grant order alone decides the surviving value and that both caches then read that same value.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_RDX = 2'd1,
    BC_UPG = 2'd2,
    BC_WB  = 2'd3
  } bus_cmd_t;

  // strobes from the controller to the tag/state/data store
  typedef struct packed {
    logic     lineWr;     // write state+tag at the processor index
    line_st_t lineState;
    logic     loadBus;    // data word from the bus response
    logic     loadCpu;    // data word from the processor
    logic     snpWr;      // write state at the snoop index
    line_st_t snpState;
  } dp_ctl_t;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [TAG_W-1:0]  cpuTag,
  input  logic [IDX_W-1:0]  snpIdx,
  input  logic [TAG_W-1:0]  snpTag,
  input  dp_ctl_t           ctl,
  input  logic [DATA_W-1:0] busRespData,
  input  logic [DATA_W-1:0] cpuWdata,
  output line_st_t          cpuSt,
  output logic              cpuHit,
  output logic [TAG_W-1:0]  cpuLineTag,
  output logic [DATA_W-1:0] cpuLineData,
  output line_st_t          snpSt,
  output logic              snpHit,
  output logic [DATA_W-1:0] snpLineData
);

  localparam int LINES = 1 << IDX_W;

  line_st_t          stArr   [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) stArr[i] <= LN_INV;
    end else begin
      if (ctl.lineWr) stArr[cpuIdx] <= ctl.lineState;
      if (ctl.snpWr)  stArr[snpIdx] <= ctl.snpState;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.lineWr) begin
      tagArr[cpuIdx] <= cpuTag;
      if (ctl.loadBus)      dataArr[cpuIdx] <= busRespData;
      else if (ctl.loadCpu) dataArr[cpuIdx] <= cpuWdata;
    end
  end

  assign cpuSt       = stArr[cpuIdx];
  assign cpuLineTag  = tagArr[cpuIdx];
  assign cpuLineData = dataArr[cpuIdx];
  assign cpuHit      = (stArr[cpuIdx] != LN_INV) && (tagArr[cpuIdx] == cpuTag);

  assign snpSt       = stArr[snpIdx];
  assign snpLineData = dataArr[snpIdx];
  assign snpHit      = (stArr[snpIdx] != LN_INV) && (tagArr[snpIdx] == snpTag);

  // R6: a snoop invalidation is never undone by a same-cycle processor update
  a_r6_snoop_inval_sticks: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.snpWr && ctl.snpState == LN_INV) |=> stArr[$past(snpIdx)] == LN_INV);

  // R5: a snoop downgrade only ever leaves a modified line
  a_r5_downgrade_from_mod: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.snpWr && ctl.snpState == LN_SHR) |-> (stArr[snpIdx] == LN_MOD && snpHit));

  // R4: an upgrade without a data load starts from a shared hit
  a_r4_upgrade_from_shr: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lineWr && ctl.lineState == LN_MOD && !ctl.loadBus && !ctl.loadCpu)
      |-> (stArr[cpuIdx] == LN_SHR && cpuHit));

  // R2: processor data lands only in an owned, matching line
  a_r2_write_hit_owned: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lineWr && ctl.loadCpu) |-> (stArr[cpuIdx] == LN_MOD && cpuHit));

endmodule

// File: rtl/coh_ctl_fsm.sv
module coh_ctl_fsm
  import coh_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuReq,
  input  logic     cpuWrite,
  input  line_st_t cpuSt,
  input  logic     cpuHit,
  input  logic     snpValid,
  input  bus_cmd_t snpCmd,
  input  line_st_t snpSt,
  input  logic     snpHit,
  input  logic     busGnt,
  output logic     cpuDone,
  output logic     busReq,
  output bus_cmd_t busCmd,
  output logic     wbSel,
  output logic     flushOut,
  output dp_ctl_t  ctl
);

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_ACQ} ctl_st_t;

  ctl_st_t st, stNext;
  logic    hitOk;
  logic    dirtyVictim;

  assign hitOk       = cpuHit && (!cpuWrite || cpuSt == LN_MOD);
  assign dirtyVictim = !cpuHit && cpuSt == LN_MOD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    ctl      = '0;
    cpuDone  = 1'b0;
    busReq   = 1'b0;
    busCmd   = BC_RD;
    wbSel    = 1'b0;
    flushOut = 1'b0;
    stNext   = st;

    // snoop side, always active
    if (snpValid && snpHit) begin
      unique case (snpCmd)
        BC_RD: if (snpSt == LN_MOD) begin
          flushOut     = 1'b1;
          ctl.snpWr    = 1'b1;
          ctl.snpState = LN_SHR;
        end
        BC_RDX: begin
          flushOut     = (snpSt == LN_MOD);
          ctl.snpWr    = 1'b1;
          ctl.snpState = LN_INV;
        end
        BC_UPG: begin
          ctl.snpWr    = 1'b1;
          ctl.snpState = LN_INV;
        end
        default: ;
      endcase
    end

    // processor side
    unique case (st)
      ST_IDLE: if (cpuReq && !snpValid) begin
        if (hitOk) begin
          cpuDone = 1'b1;
          if (cpuWrite) begin
            ctl.lineWr    = 1'b1;
            ctl.lineState = LN_MOD;
            ctl.loadCpu   = 1'b1;
          end
        end else if (dirtyVictim) begin
          stNext = ST_WB;
        end else begin
          stNext = ST_ACQ;
        end
      end
      ST_WB: begin
        wbSel = 1'b1;
        if (cpuSt == LN_MOD) begin
          busReq = 1'b1;
          busCmd = BC_WB;
          if (busGnt) begin
            ctl.lineWr    = 1'b1;
            ctl.lineState = LN_INV;
            stNext        = ST_ACQ;
          end
        end else begin
          stNext = ST_ACQ;   // victim was taken by a snoop meanwhile
        end
      end
      ST_ACQ: begin
        busReq = 1'b1;
        if (!cpuWrite)                      busCmd = BC_RD;
        else if (cpuHit && cpuSt == LN_SHR) busCmd = BC_UPG;
        else                                busCmd = BC_RDX;
        if (busGnt) begin
          ctl.lineWr    = 1'b1;
          ctl.lineState = cpuWrite ? LN_MOD : LN_SHR;
          ctl.loadBus   = (busCmd != BC_UPG);
          stNext        = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  // R8: snoops win over processor completion
  a_r8_snoop_blocks_cpu: assert property (@(posedge clk) disable iff (!rstN)
    snpValid |-> !cpuDone);

  // R7: a granted writeback is followed by a fill request
  a_r7_fill_after_wb: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt && busCmd == BC_WB) |=> (busReq && busCmd != BC_WB));

  // R1: no transaction or completion without a pending processor request
  a_r1_quiet_without_req: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && !cpuReq) |-> (!busReq && !cpuDone));

endmodule

// File: rtl/coh_snoop_cache.sv
module coh_snoop_cache
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGnt,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  input  logic [DATA_W-1:0] busRespData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              flushOut,
  output logic [DATA_W-1:0] flushData
);

  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpuIdx, snpIdx;
  logic [TAG_W-1:0]  cpuTag, snpTag, cpuLineTag;
  logic [DATA_W-1:0] cpuLineData, snpLineData;
  line_st_t          cpuSt, snpSt;
  logic              cpuHit, snpHit, wbSel;
  bus_cmd_t          busCmdE;
  dp_ctl_t           ctl;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  coh_line_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) uStore (
    .clk         (clk),
    .rstN        (rstN),
    .cpuIdx      (cpuIdx),
    .cpuTag      (cpuTag),
    .snpIdx      (snpIdx),
    .snpTag      (snpTag),
    .ctl         (ctl),
    .busRespData (busRespData),
    .cpuWdata    (cpuWdata),
    .cpuSt       (cpuSt),
    .cpuHit      (cpuHit),
    .cpuLineTag  (cpuLineTag),
    .cpuLineData (cpuLineData),
    .snpSt       (snpSt),
    .snpHit      (snpHit),
    .snpLineData (snpLineData)
  );

  coh_ctl_fsm uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .cpuWrite (cpuWrite),
    .cpuSt    (cpuSt),
    .cpuHit   (cpuHit),
    .snpValid (snpValid),
    .snpCmd   (bus_cmd_t'(snpCmd)),
    .snpSt    (snpSt),
    .snpHit   (snpHit),
    .busGnt   (busGnt),
    .cpuDone  (cpuDone),
    .busReq   (busReq),
    .busCmd   (busCmdE),
    .wbSel    (wbSel),
    .flushOut (flushOut),
    .ctl      (ctl)
  );

  assign busCmd    = busCmdE;
  assign busAddr   = wbSel ? {cpuLineTag, cpuIdx} : cpuAddr;
  assign busData   = cpuLineData;
  assign flushData = snpLineData;
  assign cpuRdata  = cpuLineData;

  // R10: an ungranted fill request keeps its request and address
  a_r10_fill_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt && busCmd != 2'd3) |=> (busReq && $stable(busAddr)));

endmodule

// File: tb/sim_coh_snoop_cache.sv
module sim_coh_snoop_cache;

  localparam int NC = 2;
  localparam int AW = 5;
  localparam int IW = 2;
  localparam int DW = 8;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          cpuReq   [NC];
  logic          cpuWrite [NC];
  logic [AW-1:0] cpuAddr  [NC];
  logic [DW-1:0] cpuWdata [NC];
  logic          cpuDone  [NC];
  logic [DW-1:0] cpuRdata [NC];
  logic          busReq   [NC];
  logic          busGnt   [NC];
  logic [1:0]    busCmd   [NC];
  logic [AW-1:0] busAddr  [NC];
  logic [DW-1:0] busData  [NC];
  logic          snpValid [NC];
  logic          flushOut [NC];
  logic [DW-1:0] flushData[NC];
  logic [DW-1:0] respData;
  logic [1:0]    snpCmd;
  logic [AW-1:0] snpAddr;

  logic [DW-1:0] mem [NA];
  int rr, gIdx;
  logic anyG, anyFlush;
  logic [DW-1:0] flushVal;

  int checks = 0, fails = 0;
  int txCnt [NC][4];
  int flushCnt, stallErr, holdErr;
  logic [AW-1:0] lastWbAddr;
  logic [DW-1:0] lastWbData;
  logic          holdPend [NC];
  logic [AW-1:0] holdAddr [NC];

  function automatic logic [DW-1:0] initVal(input int a);
    return DW'(a * 37 + 11);
  endfunction

  for (genvar i = 0; i < NC; i++) begin : gc
    coh_snoop_cache #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u0 (
      .clk(clk), .rstN(rstN),
      .cpuReq(cpuReq[i]), .cpuWrite(cpuWrite[i]), .cpuAddr(cpuAddr[i]),
      .cpuWdata(cpuWdata[i]), .cpuDone(cpuDone[i]), .cpuRdata(cpuRdata[i]),
      .busReq(busReq[i]), .busGnt(busGnt[i]), .busCmd(busCmd[i]),
      .busAddr(busAddr[i]), .busData(busData[i]), .busRespData(respData),
      .snpValid(snpValid[i]), .snpCmd(snpCmd), .snpAddr(snpAddr),
      .flushOut(flushOut[i]), .flushData(flushData[i])
    );
  end

  // round-robin bus, one transaction per cycle
  always_comb begin
    anyG = 1'b0;
    gIdx = 0;
    for (int k = NC - 1; k >= 0; k--) begin
      if (busReq[(rr + k) % NC]) begin
        anyG = 1'b1;
        gIdx = (rr + k) % NC;
      end
    end
    anyFlush = 1'b0;
    flushVal = '0;
    for (int i = 0; i < NC; i++) begin
      busGnt[i]   = anyG && (gIdx == i);
      snpValid[i] = anyG && (gIdx != i);
      if (flushOut[i]) begin
        anyFlush = 1'b1;
        flushVal = flushVal | flushData[i];
      end
    end
    snpCmd   = busCmd[gIdx];
    snpAddr  = busAddr[gIdx];
    respData = anyFlush ? flushVal : mem[busAddr[gIdx]];
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < NA; a++) mem[a] <= initVal(a);
      rr <= 0;
      for (int i = 0; i < NC; i++) begin
        holdPend[i] <= 1'b0;
        holdAddr[i] <= '0;
        for (int k = 0; k < 4; k++) txCnt[i][k] = 0;
      end
      flushCnt = 0; stallErr = 0; holdErr = 0;
    end else begin
      if (anyG) begin
        txCnt[gIdx][busCmd[gIdx]]++;
        if (busCmd[gIdx] == 2'd3) begin
          lastWbAddr = busAddr[gIdx];
          lastWbData = busData[gIdx];
          mem[busAddr[gIdx]] <= busData[gIdx];
        end
        if (anyFlush) begin
          flushCnt++;
          mem[busAddr[gIdx]] <= flushVal;
        end
        rr <= (gIdx + 1) % NC;
      end
      for (int i = 0; i < NC; i++) begin
        if (snpValid[i] && cpuDone[i]) stallErr++;
        if (holdPend[i] && !(busReq[i] && busAddr[i] == holdAddr[i])) holdErr++;
        holdPend[i] <= busReq[i] && !busGnt[i] && busCmd[i] != 2'd3;
        holdAddr[i] <= busAddr[i];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doOp(input int c, input bit wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, output logic [DW-1:0] rd);
    @(negedge clk);
    cpuReq[c] = 1'b1; cpuWrite[c] = wr; cpuAddr[c] = a; cpuWdata[c] = d;
    #1;
    while (!cpuDone[c]) begin
      @(negedge clk);
      #1;
    end
    rd = cpuRdata[c];
    @(posedge clk);
    #1;
    cpuReq[c] = 1'b0;
  endtask

  function automatic int totTx(input int c);
    return txCnt[c][0] + txCnt[c][1] + txCnt[c][2] + txCnt[c][3];
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] rd, q0, q1, r0, r1;
    logic [DW-1:0] gold [NA];
    int b, b2, f;
    logic [31:0] x;

    for (int i = 0; i < NC; i++) begin
      cpuReq[i] = 1'b0; cpuWrite[i] = 1'b0; cpuAddr[i] = '0; cpuWdata[i] = '0;
    end
    for (int a = 0; a < NA; a++) gold[a] = initVal(a);
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk); #1;
    chk(!busReq[0] && !busReq[1], "R1 busReq low after reset", int'(busReq[0]) + int'(busReq[1]), 0);
    chk(!flushOut[0] && !flushOut[1] && !cpuDone[0] && !cpuDone[1],
        "R1 flush/done low after reset", int'(flushOut[0]) + int'(cpuDone[0]), 0);

    // load miss: shared read
    b = txCnt[0][0];
    doOp(0, 0, 5'd5, 8'h00, rd);
    chk(rd == initVal(5), "R3 miss data", rd, initVal(5));
    chk(txCnt[0][0] == b + 1, "R1 R3 first load issues shared read", txCnt[0][0], b + 1);
    b = txCnt[1][0];
    doOp(1, 0, 5'd18, 8'h00, rd);
    chk(txCnt[1][0] == b + 1 && rd == initVal(18), "R1 second cache starts invalid", txCnt[1][0], b + 1);

    // load hit
    b = totTx(0);
    doOp(0, 0, 5'd5, 8'h00, rd);
    chk(totTx(0) == b, "R2 load hit no bus", totTx(0), b);
    chk(rd == initVal(5), "R2 load hit data", rd, initVal(5));

    // store to shared line -> upgrade
    b = txCnt[0][2]; b2 = txCnt[0][1];
    doOp(0, 1, 5'd5, 8'hA5, rd);
    chk(txCnt[0][2] == b + 1 && txCnt[0][1] == b2, "R4 shared store upgrades", txCnt[0][2], b + 1);

    // store hit on modified
    b = totTx(0);
    doOp(0, 1, 5'd5, 8'h5A, rd);
    chk(totTx(0) == b, "R2 store hit modified no bus", totTx(0), b);

    // snooped read hits modified
    f = flushCnt;
    doOp(1, 0, 5'd5, 8'h00, rd);
    chk(rd == 8'h5A, "R5 flushed data to reader", rd, 8'h5A);
    chk(flushCnt == f + 1, "R5 flush asserted", flushCnt, f + 1);
    b = txCnt[0][2];
    doOp(0, 1, 5'd5, 8'h11, rd);
    chk(txCnt[0][2] == b + 1, "R5 owner kept line shared", txCnt[0][2], b + 1);
    b = txCnt[1][0];
    doOp(1, 0, 5'd5, 8'h00, rd);
    chk(txCnt[1][0] == b + 1, "R6 upgrade invalidated other copy", txCnt[1][0], b + 1);
    chk(rd == 8'h11, "R9 read after upgrade", rd, 8'h11);

    // snooped exclusive read hits modified
    doOp(1, 1, 5'd5, 8'h22, rd);
    b = txCnt[0][1]; f = flushCnt;
    doOp(0, 1, 5'd5, 8'h33, rd);
    chk(txCnt[0][1] == b + 1, "R4 store to invalid line uses exclusive read", txCnt[0][1], b + 1);
    chk(flushCnt == f + 1, "R6 modified copy flushed on exclusive read", flushCnt, f + 1);
    b = txCnt[1][0];
    doOp(1, 0, 5'd5, 8'h00, rd);
    chk(txCnt[1][0] == b + 1, "R6 exclusive read invalidated owner", txCnt[1][0], b + 1);
    chk(rd == 8'h33, "R9 read after exclusive read", rd, 8'h33);

    // evictions on index 1
    b = txCnt[0][3]; b2 = txCnt[0][1];
    doOp(0, 1, 5'd9, 8'h44, rd);
    chk(txCnt[0][3] == b, "R7 clean victim no writeback", txCnt[0][3], b);
    chk(txCnt[0][1] == b2 + 1, "R4 conflicting store exclusive read", txCnt[0][1], b2 + 1);
    b = txCnt[0][3]; b2 = txCnt[0][1];
    doOp(0, 1, 5'd13, 8'h55, rd);
    chk(txCnt[0][3] == b + 1 && txCnt[0][1] == b2 + 1, "R7 dirty victim writeback then fill", txCnt[0][3], b + 1);
    chk(lastWbAddr == 5'd9, "R7 writeback address", lastWbAddr, 9);
    chk(lastWbData == 8'h44, "R7 writeback data", lastWbData, 8'h44);
    doOp(1, 0, 5'd9, 8'h00, rd);
    chk(rd == 8'h44, "R9 evicted value in memory", rd, 8'h44);
    doOp(0, 0, 5'd13, 8'h00, rd);
    chk(rd == 8'h55, "R2 new line readable", rd, 8'h55);
    gold[5] = 8'h33; gold[9] = 8'h44; gold[13] = 8'h55;

    // sweep
    x = 32'h1234_5678;
    for (int n = 0; n < 1200; n++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      doOp(int'(x[31]), x[30], x[20:16], x[15:8], rd);
      if (x[30]) gold[x[20:16]] = x[15:8];
      else chk(rd == gold[x[20:16]], "R9 sweep load", rd, gold[x[20:16]]);
    end

    // racing stores
    for (int a = 0; a < 12; a++) begin
      fork
        doOp(0, 1, AW'(a), DW'(8'hC0 + a), r0);
        doOp(1, 1, AW'(a), DW'(8'h60 + a), r1);
      join
      fork
        doOp(0, 0, AW'(a), 8'h00, q0);
        doOp(1, 0, AW'(a), 8'h00, q1);
      join
      chk(q0 == q1, "R9 caches agree after racing stores", q0, q1);
      chk(q0 == DW'(8'hC0 + a) || q0 == DW'(8'h60 + a), "R9 survivor is one of the stores", q0, 8'hC0 + a);
    end

    chk(stallErr == 0, "R8 no completion during snoop", stallErr, 0);
    chk(holdErr == 0, "R10 fill request held", holdErr, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule